// File: doc/BRIEF.md
# Programmable Waveform Bus Master

This block drives an external parallel bus with timing taken from a small table of waveform descriptors instead of a fixed protocol machine. A host fills the table through a simple write port. Each descriptor sets the levels of six control outputs and names a condition on six ready inputs. The engine stays on a descriptor until that condition holds, then moves to the descriptor the entry names. A descriptor may also move one data word between the bus and a FIFO and step a 9-bit byte address. The descriptor flagged as the end of the waveform closes one transaction.

A start strobe copies a 32-bit transaction count, written beforehand as four bytes, into a down-counter. The engine then repeats the waveform until the count runs out, and the counter always shows the transactions still to go. When the FIFO cannot supply or accept a word, the engine holds the descriptor instead of moving on. A one-cycle pulse marks the end of each waveform, and another marks the end of the whole operation. The data bus can run 8 or 16 bits wide, and words can move from the FIFO to the bus or from the bus to the FIFO.

Top module: `wavebus_master`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `ctl_out`, `addr_out`, `remaining`, `busy`, `done`, `wave_evt`, `fifo_rd`, `fifo_wr` and `bus_oe` are all zero.
- R2: A write with `cnt_we` high stores `cnt_wdata` into bits [8k+7:8k] of the programmed count, where k = `cnt_sel`. An accepted start copies the programmed count into `remaining`. `remaining` falls by exactly one at the clock edge that ends each waveform.
- R3: A descriptor word is laid out as ctl [5:0], ready mask [11:6], ready match [17:12], next index [20:18], FIFO advance [21], address increment [22] and end of waveform [23]. A write with `dsc_we` high stores it at entry `dsc_idx` (0 to 7).
- R4: While busy, `ctl_out` equals the ctl field of the current descriptor and changes only at a clock edge. It is zero while idle, including the cycle after completion.
- R5: The engine stays on the current descriptor while ((`rdy_in` XOR match) AND mask) is nonzero. Ready bits outside the mask have no effect. When the condition holds, the next clock edge moves it to the next-index entry, or to entry 0 if the end flag is set. A start begins at entry 0.
- R6: When a descriptor with FIFO advance is left with `dir_write`=1, `fifo_rd` is high for that cycle, and the popped word appears on `bus_dout` after the edge. With `dir_write`=0, `fifo_wr` is high instead and `fifo_wr_data` carries `bus_din`. With `wide`=0 the upper byte of either word is zero.
- R7: A descriptor with FIFO advance does not complete while `fifo_empty` (with `dir_write`=1) or `fifo_full` (with `dir_write`=0) is high. No pop or push strobe is issued while it waits.
- R8: A start loads `addr_out` from `addr_base`. Leaving a descriptor with address increment adds 2 when `wide`=1 and 1 when `wide`=0, modulo 512.
- R9: `busy` falls and `done` pulses for one cycle after the edge that ends the last transaction. `wave_evt` pulses for one cycle after each completed waveform. A start with a programmed count of zero gives only a `done` pulse and no run.
- R10: A start while busy, including in the cycle of the final step, is ignored. `remaining` and the descriptor sequence are unaffected, and no new run follows.
- R11: `bus_oe` is high exactly while busy with `dir_write`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsc_we | input | 1 | Descriptor write enable |
| dsc_idx | input | 3 | Descriptor entry to write |
| dsc_wdata | input | 24 | Descriptor word (layout in R3) |
| cnt_we | input | 1 | Count byte write enable |
| cnt_sel | input | 2 | Count byte lane |
| cnt_wdata | input | 8 | Count byte value |
| start | input | 1 | Start strobe |
| dir_write | input | 1 | 1: FIFO to bus, 0: bus to FIFO |
| wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| addr_base | input | 9 | Address loaded at start |
| rdy_in | input | 6 | Ready inputs |
| ctl_out | output | 6 | Control outputs |
| addr_out | output | 9 | Bus byte address |
| bus_din | input | 16 | Data read from the bus |
| bus_dout | output | 16 | Data driven onto the bus |
| bus_oe | output | 1 | Bus data output enable |
| fifo_rd | output | 1 | FIFO pop strobe |
| fifo_rd_data | input | 16 | FIFO head word |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_wr | output | 1 | FIFO push strobe |
| fifo_wr_data | output | 16 | Word pushed into the FIFO |
| fifo_full | input | 1 | FIFO has no room |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wave_evt | output | 1 | One-cycle end-of-waveform pulse |
| remaining | output | 32 | Transactions still to run |

## Verification
Two events can fall in the same cycle: the step that ends the last transaction and a new start strobe. The bench raises `start` in the cycle where the final descriptor is being left, on every one of its transfer runs. It then expects the run to close normally: `busy` low, one `done` pulse, `remaining` at zero, and no new run in the following cycle. A second collision pairs a satisfied ready condition with a blocked FIFO. Here the bench expects the engine to hold with no strobe until the FIFO flag clears.

// File: rtl/wvb_pkg.sv
`timescale 1ns/1ps
package wvb_pkg;
  localparam int SIG_W = 6;
  localparam int IDX_W = 3;
  localparam int DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic             last;
    logic             addr_inc;
    logic             fifo_adv;
    logic [IDX_W-1:0] nxt;
    logic [SIG_W-1:0] match;
    logic [SIG_W-1:0] mask;
    logic [SIG_W-1:0] ctl;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;
endpackage

// File: rtl/wvb_desc_table.sv
`timescale 1ns/1ps
module wvb_desc_table
  import wvb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  desc_t            wdata,
  input  logic [IDX_W-1:0] ridx_a,
  input  logic [IDX_W-1:0] ridx_b,
  output desc_t            rdata_a,
  output desc_t            rdata_b
);
  logic [DEPTH-1:0][DESC_W-1:0] ent_flat;

  // one register per entry, each with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    desc_t ent_q;
    logic  ent_en;
    assign ent_en = we && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= wdata;
    end
    assign ent_flat[g] = ent_q;
  end

  assign rdata_a = desc_t'(ent_flat[ridx_a]);
  assign rdata_b = desc_t'(ent_flat[ridx_b]);
endmodule

// File: rtl/wvb_xfer_count.sv
`timescale 1ns/1ps
module wvb_xfer_count #(
  parameter  int CNT_W = 32,
  localparam int NBYTE = CNT_W / 8,
  localparam int SEL_W = $clog2(NBYTE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_we,
  input  logic [SEL_W-1:0] byte_sel,
  input  logic [7:0]       byte_data,
  input  logic             load,
  input  logic             dec,
  output logic [CNT_W-1:0] remaining,
  output logic             prog_zero,
  output logic             last_one
);
  logic [CNT_W-1:0] prog;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             rem_en;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    logic [7:0] byte_q;
    logic       byte_en;
    assign byte_en = byte_we && (byte_sel == SEL_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_en) byte_q <= byte_data;
    end
    assign prog[8*b +: 8] = byte_q;
  end

  always_comb begin
    rem_en = load || dec;
    rem_d  = load ? prog : (rem_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign remaining = rem_q;
  assign prog_zero = (prog == '0);
  assign last_one  = (rem_q == CNT_W'(1));
endmodule

// File: rtl/wvb_seq.sv
`timescale 1ns/1ps
module wvb_seq
  import wvb_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_write,
  input  logic              wide,
  input  logic              prog_zero,
  input  logic              last_txn,
  input  logic [ADDR_W-1:0] addr_base,
  input  logic [SIG_W-1:0]  rdy_in,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  desc_t             cur_desc,
  input  logic [SIG_W-1:0]  nxt_ctl,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  nxt_idx,
  output logic              busy,
  output logic              launch,
  output logic              step,
  output logic              wave_end,
  output logic [SIG_W-1:0]  ctl_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic              done,
  output logic              wave_evt
);
  seq_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic [SIG_W-1:0]  ctl_q, ctl_d;
  logic              ctl_en;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              done_q, evt_q;
  logic              ready_ok, fifo_block, finish, zero_run;

  always_comb begin
    ready_ok   = (((rdy_in ^ cur_desc.match) & cur_desc.mask) == '0);
    fifo_block = cur_desc.fifo_adv && (dir_write ? fifo_empty : fifo_full);
    step       = (state_q == ST_RUN) && ready_ok && !fifo_block;
    wave_end   = step && cur_desc.last;
    finish     = wave_end && last_txn;
    launch     = (state_q == ST_IDLE) && start && !prog_zero;
    zero_run   = (state_q == ST_IDLE) && start && prog_zero;

    state_d = state_q;
    if (launch)      state_d = ST_RUN;
    else if (finish) state_d = ST_IDLE;

    idx_en = launch || step;
    if (launch)             idx_d = '0;
    else if (cur_desc.last) idx_d = '0;
    else                    idx_d = cur_desc.nxt;

    ctl_en = launch || step;
    ctl_d  = finish ? '0 : nxt_ctl;

    addr_en = launch || (step && cur_desc.addr_inc);
    addr_d  = launch ? addr_base
                     : addr_q + (wide ? ADDR_W'(2) : ADDR_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      done_q <= finish || zero_run;
      evt_q  <= wave_end;
    end
  end

  assign cur_idx  = idx_q;
  assign nxt_idx  = launch ? '0 : idx_d;
  assign busy     = (state_q == ST_RUN);
  assign ctl_out  = ctl_q;
  assign addr_out = addr_q;
  assign done     = done_q;
  assign wave_evt = evt_q;
endmodule

// File: rtl/wavebus_master.sv
`timescale 1ns/1ps
module wavebus_master
  import wvb_pkg::*;
#(
  parameter  int ADDR_W = 9,
  parameter  int DATA_W = 16,
  parameter  int CNT_W  = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int SEL_W  = $clog2(CNT_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsc_we,
  input  logic [IDX_W-1:0]  dsc_idx,
  input  logic [DESC_W-1:0] dsc_wdata,
  input  logic              cnt_we,
  input  logic [SEL_W-1:0]  cnt_sel,
  input  logic [7:0]        cnt_wdata,
  input  logic              start,
  input  logic              dir_write,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr_base,
  input  logic [SIG_W-1:0]  rdy_in,
  output logic [SIG_W-1:0]  ctl_out,
  output logic [ADDR_W-1:0] addr_out,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              fifo_rd,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_empty,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wr_data,
  input  logic              fifo_full,
  output logic              busy,
  output logic              done,
  output logic              wave_evt,
  output logic [CNT_W-1:0]  remaining
);
  desc_t             cur_desc, nxt_desc;
  logic [IDX_W-1:0]  cur_idx, nxt_idx;
  logic              launch, step, wave_end;
  logic              prog_zero, last_one;
  logic              xfer;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              dout_en;

  wvb_desc_table u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (dsc_we),
    .widx    (dsc_idx),
    .wdata   (desc_t'(dsc_wdata)),
    .ridx_a  (cur_idx),
    .ridx_b  (nxt_idx),
    .rdata_a (cur_desc),
    .rdata_b (nxt_desc)
  );

  wvb_xfer_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_we   (cnt_we),
    .byte_sel  (cnt_sel),
    .byte_data (cnt_wdata),
    .load      (launch),
    .dec       (wave_end),
    .remaining (remaining),
    .prog_zero (prog_zero),
    .last_one  (last_one)
  );

  wvb_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dir_write  (dir_write),
    .wide       (wide),
    .prog_zero  (prog_zero),
    .last_txn   (last_one),
    .addr_base  (addr_base),
    .rdy_in     (rdy_in),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .cur_desc   (cur_desc),
    .nxt_ctl    (nxt_desc.ctl),
    .cur_idx    (cur_idx),
    .nxt_idx    (nxt_idx),
    .busy       (busy),
    .launch     (launch),
    .step       (step),
    .wave_end   (wave_end),
    .ctl_out    (ctl_out),
    .addr_out   (addr_out),
    .done       (done),
    .wave_evt   (wave_evt)
  );

  // data path: one word moves when a FIFO-advance descriptor is left
  always_comb begin
    xfer    = step && cur_desc.fifo_adv;
    dout_en = xfer && dir_write;
    dout_d  = wide ? fifo_rd_data : {{HALF_W{1'b0}}, fifo_rd_data[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= dout_d;
  end

  assign bus_dout     = dout_q;
  assign bus_oe       = busy && dir_write;
  assign fifo_rd      = xfer && dir_write;
  assign fifo_wr      = xfer && !dir_write;
  assign fifo_wr_data = wide ? bus_din : {{HALF_W{1'b0}}, bus_din[HALF_W-1:0]};
endmodule

// File: rtl/wvb_checker.sv
`timescale 1ns/1ps
module wvb_checker #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 32,
  parameter int CTL_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fifo_rd,
  input logic              fifo_wr,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic [CTL_W-1:0]  ctl_out,
  input logic [ADDR_W-1:0] addr_out,
  input logic [CNT_W-1:0]  remaining
);
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd |-> !fifo_empty); // R7
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n) fifo_wr |-> !fifo_full); // R7
  AST_IDLE_CTL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (ctl_out == '0)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (fifo_rd || fifo_wr) |-> busy); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> ((remaining == $past(remaining)) || (remaining == $past(remaining) - CNT_W'(1)))); // R2
  AST_ADDR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && $past(!busy)) |-> $stable(addr_out)); // R8
endmodule

bind wavebus_master wvb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTL_W(wvb_pkg::SIG_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .fifo_rd    (fifo_rd),
  .fifo_wr    (fifo_wr),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .ctl_out    (ctl_out),
  .addr_out   (addr_out),
  .remaining  (remaining)
);

// File: tb/test_wavebus_master.sv
`timescale 1ns/1ps
module test_wavebus_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dsc_we;
  logic [2:0]  dsc_idx;
  logic [23:0] dsc_wdata;
  logic        cnt_we;
  logic [1:0]  cnt_sel;
  logic [7:0]  cnt_wdata;
  logic        start, dir_write, wide;
  logic [8:0]  addr_base;
  logic [5:0]  rdy;
  logic [5:0]  ctl_out;
  logic [8:0]  addr_out;
  logic [15:0] bus_din, bus_dout, fifo_rd_data, fifo_wr_data;
  logic        bus_oe, fifo_rd, fifo_empty, fifo_wr, fifo_full;
  logic        busy, done, wave_evt;
  logic [31:0] remaining;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [15:0] pops = 16'd0;

  always #2.5 clk = ~clk;

  wavebus_master i_wavebus_master (
    .clk(clk), .rst_n(rst_n), .dsc_we(dsc_we), .dsc_idx(dsc_idx), .dsc_wdata(dsc_wdata),
    .cnt_we(cnt_we), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata), .start(start),
    .dir_write(dir_write), .wide(wide), .addr_base(addr_base), .rdy_in(rdy),
    .ctl_out(ctl_out), .addr_out(addr_out), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .fifo_rd(fifo_rd), .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
    .fifo_wr(fifo_wr), .fifo_wr_data(fifo_wr_data), .fifo_full(fifo_full),
    .busy(busy), .done(done), .wave_evt(wave_evt), .remaining(remaining)
  );

  // external FIFO model: head word derived from the number of pops so far
  function automatic logic [15:0] head_word(input logic [15:0] p);
    return {p[7:0] ^ 8'h96, p[7:0] + 8'h11};
  endfunction
  assign fifo_rd_data = head_word(pops);
  always @(posedge clk) if (fifo_rd === 1'b1) pops <= pops + 16'd1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; dsc_we = 0; dsc_idx = 0; dsc_wdata = 0; cnt_we = 0; cnt_sel = 0;
    cnt_wdata = 0; start = 0; dir_write = 0; wide = 0; addr_base = 0; rdy = 0;
    bus_din = 0; fifo_empty = 0; fifo_full = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_desc(input logic [2:0] idx, input logic [5:0] c, input logic [5:0] m,
                         input logic [5:0] v, input logic [2:0] nx, input logic fa,
                         input logic ai, input logic lst);
    dsc_we = 1'b1; dsc_idx = idx; dsc_wdata = {lst, ai, fa, nx, v, m, c};
    @(negedge clk);
    dsc_we = 1'b0;
  endtask

  task automatic wr_count(input logic [31:0] val);
    for (int b = 0; b < 4; b++) begin
      cnt_we = 1'b1; cnt_sel = 2'(b); cnt_wdata = val[8*b +: 8];
      @(negedge clk);
    end
    cnt_we = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    logic [5:0]  ctl_seq [3];
    logic [8:0]  base, inc;
    logic [15:0] p0;
    int          n;
    ctl_seq[0] = 6'h01; ctl_seq[1] = 6'h12; ctl_seq[2] = 6'h24;

    // ---- R1 reset state
    do_reset();
    chk("R1 ctl", 32'(ctl_out), 0);
    chk("R1 addr", 32'(addr_out), 0);
    chk("R1 remaining", remaining, 0);
    chk("R1 flags", {busy, done, wave_evt, fifo_rd, fifo_wr, bus_oe}, 0);

    // ---- R2 count byte lanes, R3 ctl field position
    for (int k = 0; k < 4; k++) begin
      for (int pi = 0; pi < 3; pi++) begin
        logic [7:0] pat;
        pat = (pi == 0) ? 8'h01 : (pi == 1) ? 8'h5A : 8'hFF;
        do_reset();
        wr_desc(3'd0, 6'h2A, 6'h3F, 6'h3F, 3'd0, 1'b0, 1'b0, 1'b1);
        wr_count(32'(pat) << (8 * k));
        pulse_start();
        chk("R2 byte lane load", remaining, 32'(pat) << (8 * k));
        chk("R3 ctl field", 32'(ctl_out), 32'h2A);
        chk("R5 holds on mismatch", 32'(busy), 1);
      end
    end

    // ---- R5 mask / match sweep
    do_reset();
    wr_count(32'd1);
    for (int m = 0; m < 64; m++) begin
      logic [5:0] v;
      v = 6'(m) ^ 6'h15;
      wr_desc(3'd0, 6'(m), 6'(m), v, 3'd0, 1'b0, 1'b0, 1'b1);
      rdy = v ^ ~6'(m);
      pulse_start();
      chk("R4 ctl while busy", 32'(ctl_out), 32'(m));
      @(negedge clk);
      chk("R5 unmasked bits ignored", {busy, done}, 2'b01);
      @(negedge clk);
      chk("R9 done one cycle", 32'(done), 0);
      if (m != 0) begin
        rdy = v ^ 6'(m);
        pulse_start();
        @(negedge clk);
        chk("R5 wait on masked mismatch", 32'(busy), 1);
        @(negedge clk);
        chk("R5 still waiting", {busy, 6'(ctl_out)}, {1'b1, 6'(m)});
        rdy = v;
        @(negedge clk);
        chk("R5 advance on match", {busy, done, 32'(remaining)}, {2'b01, 32'd0});
        @(negedge clk);
      end
    end

    // ---- R6 R8 R9 R10 R11 transfer sweep, chain 0 -> 3 -> 6
    do_reset();
    wr_desc(3'd0, 6'h01, 6'h00, 6'h00, 3'd3, 1'b0, 1'b0, 1'b0);
    wr_desc(3'd3, 6'h12, 6'h01, 6'h01, 3'd6, 1'b1, 1'b1, 1'b0);
    wr_desc(3'd6, 6'h24, 6'h00, 6'h00, 3'd2, 1'b0, 1'b0, 1'b1);
    rdy = 6'h01;
    for (int w = 0; w < 2; w++) begin
      for (int d = 0; d < 2; d++) begin
        for (int bi = 0; bi < 3; bi++) begin
          for (int ni = 0; ni < 2; ni++) begin
            base = (bi == 0) ? 9'h000 : (bi == 1) ? 9'h1FE : 9'h1FF;
            n = (ni == 0) ? 1 : 4;
            inc = (w == 1) ? 9'd2 : 9'd1;
            wr_count(32'(n));
            wide = w[0]; dir_write = d[0]; addr_base = base;
            p0 = pops;
            pulse_start();
            for (int t = 0; t < n; t++) begin
              for (int c = 0; c < 3; c++) begin
                chk("R4 ctl sequence", 32'(ctl_out), 32'(ctl_seq[c]));
                chk("R2 remaining", remaining, 32'(n - t));
                chk("R8 address", 32'(addr_out),
                    32'(9'(base + 9'(t + (c == 2 ? 1 : 0)) * inc)));
                chk("R11 output enable", 32'(bus_oe), 32'(d));
                if (c == 1) begin
                  chk("R6 pop strobe", {fifo_rd, fifo_wr}, {d[0], ~d[0]});
                  if (d == 0)
                    chk("R6 push data", 32'(fifo_wr_data),
                        32'(w == 1 ? bus_din : {8'h00, bus_din[7:0]}));
                end
                if (c == 2 && d == 1) begin
                  logic [15:0] hw;
                  hw = head_word(p0 + 16'(t));
                  chk("R6 bus data", 32'(bus_dout), 32'(w == 1 ? hw : {8'h00, hw[7:0]}));
                end
                if (c == 0 && t > 0) chk("R9 wave event", 32'(wave_evt), 1);
                if (c == 0) bus_din = {8'hC3, 8'(t * 37 + 5)};
                start = (t == 0 && c == 1) || (t == n - 1 && c == 2);
                @(negedge clk);
              end
            end
            start = 1'b0;
            chk("R9 end of run", {busy, done, wave_evt}, 3'b011);
            chk("R4 ctl idle", 32'(ctl_out), 0);
            chk("R10 remaining after run", remaining, 0);
            chk("R8 final address", 32'(addr_out), 32'(9'(base + 9'(n) * inc)));
            @(negedge clk);
            chk("R10 start at final step ignored", {busy, done}, 2'b00);
          end
        end
      end
    end

    // ---- R7 FIFO stall, both directions
    for (int d = 1; d >= 0; d--) begin
      do_reset();
      wr_desc(3'd0, 6'h07, 6'h00, 6'h00, 3'd0, 1'b1, 1'b0, 1'b1);
      wr_count(32'd2);
      dir_write = d[0];
      fifo_empty = (d == 1); fifo_full = (d == 0);
      pulse_start();
      for (int k = 0; k < 3; k++) begin
        chk("R7 no strobe while blocked", {fifo_rd, fifo_wr, busy}, 3'b001);
        chk("R7 count held", remaining, 2);
        @(negedge clk);
      end
      fifo_empty = 1'b0; fifo_full = 1'b0;
      #1;
      chk("R7 strobe after release", {fifo_rd, fifo_wr}, {d[0], ~d[0]});
      @(negedge clk);
      chk("R7 first transaction", {busy, wave_evt, 32'(remaining)}, {2'b11, 32'd1});
      @(negedge clk);
      chk("R9 finish after stall", {busy, done}, 2'b01);
    end

    // ---- R9 zero count
    do_reset();
    wr_count(32'd0);
    pulse_start();
    chk("R9 zero count", {busy, done, wave_evt}, 3'b010);
    @(negedge clk);
    chk("R9 zero count pulse ends", 32'(done), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule